// File: doc/BRIEF.md
# Cycle or Scanline Interrupt Timer

This block raises the cartridge-side interrupt for a game-console memory mapper. An 8-bit up-counter starts from a software-written reload value and advances either once per CPU cycle or once per video scanline. When it passes its top value, it restarts from the reload value and asserts an active-low interrupt line. Scanlines are not detected from the video bus. A fractional prescaler produces one count step for every 341/3 CPU cycles instead.

Software sees three write-only registers, each selected by its own decoded write strobe:
- **Reload value:** holds the value the counter restarts from.
- **Control:** picks the counting source, enables the timer and stores a restore bit.
- **Acknowledge:** clears the interrupt and puts the stored restore bit back into the enable.

Top module: `irq_tmr_top`

## Requirements
- R1: After reset, `irq_no` is 1. The reload value, the counter, the enable, the mode and the restore bit are all 0, and mode 0 means scanline mode.
- R2: A reload write stores `wdata_i` as the reload value. It does not change the running count. The stored value is used at the next control load or the next wrap.
- R3: A control write decodes `wdata_i` as follows: bit 2 is the mode (1 = CPU cycle, 0 = scanline), bit 1 is the enable and bit 0 is the restore bit. Every control write clears a pending interrupt. When bit 1 is 1, the write also loads the counter from the reload value and restarts the prescaler.
- R4: In cycle mode, the enabled counter adds 1 on each edge with `cpu_ce_i` high. If the counter was loaded with L, the first wrap comes 256-L strobes after the load, and later wraps follow every 256-L strobes.
- R5: In scanline mode, each strobe subtracts 3 from an accumulator that starts at 341. When the result is 0 or below, the counter steps and 341 is added back. After a restart, steps therefore come 114, 114 and then 113 strobes apart, and the pattern repeats.
- R6: The counter and the prescaler hold their state when the timer is disabled or `cpu_ce_i` is low.
- R7: An acknowledge write clears the pending interrupt and copies the restore bit into the enable, whatever the value of `wdata_i`. If a control write comes in the same cycle, the control write decides the enable.
- R8: A wrap while enabled asserts `irq_no` low at the same edge. The line stays low until an acknowledge write or a control write, including across later wraps.
- R9: In a cycle with a control write or an acknowledge write, `cpu_ce_i` is ignored and no count step happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_ce_i | input | 1 | CPU cycle strobe, one clock wide |
| wr_reload_i | input | 1 | Write strobe for the reload value |
| wr_ctrl_i | input | 1 | Write strobe for the control register |
| wr_ack_i | input | 1 | Write strobe for the acknowledge register |
| wdata_i | input | 8 | Write data |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
Every write takes effect at the edge where its strobe is sampled, and a wrap drives `irq_no` low at that same edge. The line is therefore due one edge after the stimulus. The exceptions are the cycle-mode wrap, due 256-L strobes after a load, and the scanline wrap, due after the summed 114/114/113 prescaler gaps. The bench applies inputs 1 ns after a rising edge and reads `irq_no` 1 ns after the next edge. It updates a cycle model that is built from the requirements at that same point, and directed tests count the strobes to the exact edge where a wrap is expected.

// File: rtl/irq_tmr_pkg.sv
package irq_tmr_pkg;
  localparam int unsigned CTRL_MODE_BIT = 2;
  localparam int unsigned CTRL_EN_BIT   = 1;
  localparam int unsigned CTRL_KEEP_BIT = 0;

  typedef struct packed {
    logic mode_cycle;
    logic enable;
    logic keep;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{mode_cycle: 1'b0, enable: 1'b0, keep: 1'b0};
endpackage

// File: rtl/irq_tmr_prescaler.sv
module irq_tmr_prescaler #(
  parameter int unsigned NUM = 341,
  parameter int unsigned DEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic adv_i,
  output logic tick_o
);
  localparam int unsigned AW = $clog2(NUM + 1);
  localparam logic [AW-1:0] NUM_V  = AW'(NUM);
  localparam logic [AW-1:0] DEN_V  = AW'(DEN);
  localparam logic [AW-1:0] WRAP_V = AW'(NUM - DEN);

  logic [AW-1:0] acc_q;
  logic          under;

  // subtracting DEN would land at or below zero
  assign under  = (acc_q <= DEN_V);
  assign tick_o = adv_i && under;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          acc_q <= NUM_V;
    else if (restart_i)   acc_q <= NUM_V;
    else if (adv_i) begin
      if (under)          acc_q <= acc_q + WRAP_V;
      else                acc_q <= acc_q - DEN_V;
    end
  end

  a_r5_acc_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_q != '0) && (acc_q <= NUM_V));

  a_r5_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (acc_q == NUM_V));

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !restart_i) |=> $stable(acc_q));
endmodule

// File: rtl/irq_tmr_counter.sv
module irq_tmr_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] latch_i,
  output logic         wrap_o,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] cnt_q;

  assign wrap_o = step_i && (cnt_q == TOP);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (load_i)   cnt_q <= latch_i;
    else if (step_i) begin
      if (cnt_q == TOP) cnt_q <= latch_i;
      else              cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r4_increment: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && (cnt_q != TOP)) |=> (cnt_q == $past(cnt_q) + 1'b1));

  a_r4_reload_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && (cnt_q == TOP)) |=> (cnt_q == $past(latch_i)));

  a_r6_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/irq_tmr_regs.sv
module irq_tmr_regs
  import irq_tmr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_reload_i,
  input  logic         wr_ctrl_i,
  input  logic         wr_ack_i,
  input  logic [W-1:0] wdata_i,
  input  logic         wrap_i,
  output logic [W-1:0] latch_o,
  output ctrl_t        ctrl_o,
  output logic         restart_o,
  output logic         pending_o
);
  logic [W-1:0] latch_q;
  ctrl_t        ctrl_q;
  logic         pend_q;

  assign restart_o = wr_ctrl_i && wdata_i[CTRL_EN_BIT];
  assign latch_o   = latch_q;
  assign ctrl_o    = ctrl_q;
  assign pending_o = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          latch_q <= '0;
    else if (wr_reload_i) latch_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= CTRL_RST;
    else if (wr_ctrl_i) begin
      ctrl_q.mode_cycle <= wdata_i[CTRL_MODE_BIT];
      ctrl_q.enable     <= wdata_i[CTRL_EN_BIT];
      ctrl_q.keep       <= wdata_i[CTRL_KEEP_BIT];
    end else if (wr_ack_i) begin
      ctrl_q.enable     <= ctrl_q.keep;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     pend_q <= 1'b0;
    else if (wr_ctrl_i || wr_ack_i)  pend_q <= 1'b0;
    else if (wrap_i)                 pend_q <= 1'b1;
  end

  a_r3_ctrl_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl_i |=> !pend_q);

  a_r7_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ack_i |=> !pend_q);

  a_r7_ack_restore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ack_i && !wr_ctrl_i) |=> (ctrl_q.enable == $past(ctrl_q.keep)));

  a_r8_hold_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !wr_ctrl_i && !wr_ack_i) |=> pend_q);

  a_r8_rise_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(wrap_i));
endmodule

// File: rtl/irq_tmr_top.sv
module irq_tmr_top
  import irq_tmr_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned PS_NUM = 341,
  parameter int unsigned PS_DEN = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cpu_ce_i,
  input  logic             wr_reload_i,
  input  logic             wr_ctrl_i,
  input  logic             wr_ack_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic             irq_no
);
  logic [CNT_W-1:0] latch;
  logic [CNT_W-1:0] cnt;
  ctrl_t            ctrl;
  logic             restart, pending, wrap, run, ps_adv, ps_tick, step;

  // register writes take the cycle; no count step alongside them
  assign run    = ctrl.enable && cpu_ce_i && !wr_ctrl_i && !wr_ack_i;
  assign ps_adv = run && !ctrl.mode_cycle;
  assign step   = ctrl.mode_cycle ? run : ps_tick;
  assign irq_no = !pending;

  irq_tmr_regs #(.W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .wr_reload_i, .wr_ctrl_i, .wr_ack_i, .wdata_i,
    .wrap_i(wrap), .latch_o(latch), .ctrl_o(ctrl),
    .restart_o(restart), .pending_o(pending)
  );

  irq_tmr_prescaler #(.NUM(PS_NUM), .DEN(PS_DEN)) u_ps (
    .clk_i, .rst_ni, .restart_i(restart), .adv_i(ps_adv), .tick_o(ps_tick)
  );

  irq_tmr_counter #(.W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .load_i(restart), .step_i(step), .latch_i(latch),
    .wrap_o(wrap), .cnt_o(cnt)
  );

  a_r9_write_blocks_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ack_i && !wr_ctrl_i) |=> $stable(cnt));

  a_r6_disabled_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl.enable && !wr_ctrl_i) |=> $stable(cnt));

  a_r3_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl_i && wdata_i[CTRL_EN_BIT]) |=> (cnt == $past(latch)));
endmodule

// File: tb/irq_tmr_tb.sv
module irq_tmr_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce = 1'b0, wr_rl = 1'b0, wr_ct = 1'b0, wr_ak = 1'b0;
  logic [7:0] wd = '0;
  logic       irq_n;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // reference state
  int m_latch = 0, m_cnt = 0, m_acc = 341;
  bit m_en = 0, m_mode = 0, m_keep = 0, m_pend = 0;

  always #2 clk = ~clk;

  irq_tmr_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cpu_ce_i(ce), .wr_reload_i(wr_rl),
    .wr_ctrl_i(wr_ct), .wr_ack_i(wr_ak), .wdata_i(wd), .irq_no(irq_n)
  );

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: irq_no=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // expected next state, straight from the requirements
  function automatic void model_step(bit c, bit rl, bit ct, bit ak, int d);
    bit stp = 0;
    bit wrp = 0;
    if (m_en && c && !ct && !ak) begin
      if (m_mode) stp = 1;
      else begin
        m_acc -= 3;
        if (m_acc <= 0) begin stp = 1; m_acc += 341; end
      end
    end
    if (stp) begin
      if (m_cnt == 255) begin wrp = 1; m_cnt = m_latch; end
      else m_cnt++;
    end
    if (ct) begin
      if (d[1]) begin m_cnt = m_latch; m_acc = 341; end
      m_mode = d[2]; m_en = d[1]; m_keep = d[0];
    end else if (ak) m_en = m_keep;
    if (ct || ak) m_pend = 0;
    else if (wrp) m_pend = 1;
    if (rl) m_latch = d;
  endfunction

  task automatic cyc(bit c, bit rl, bit ct, bit ak, logic [7:0] d, string req);
    ce = c; wr_rl = rl; wr_ct = ct; wr_ak = ak; wd = d;
    @(posedge clk); #1;
    model_step(c, rl, ct, ak, int'(d));
    ce = 0; wr_rl = 0; wr_ct = 0; wr_ak = 0;
    check(req, irq_n, !m_pend);
  endtask

  task automatic run_ce(int n, string req);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, 8'h00, req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: irq_no=%0b expected completion", irq_n);
    finish_run();
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd4242);
    repeat (3) @(posedge clk);
    #1 check("R1 reset irq high", irq_n, 1'b1);
    rst_n = 1'b1;
    // R6: counting with enable clear does nothing
    run_ce(300, "R6 disabled no irq");
    check("R6 disabled irq high", irq_n, 1'b1);

    // R4: cycle mode, L=FE -> wrap on second strobe
    cyc(0, 1, 0, 0, 8'hFE, "R2 reload write");
    cyc(0, 0, 1, 0, 8'h06, "R3 ctrl enable cycle");
    cyc(1, 0, 0, 0, 0, "R4 first strobe");
    check("R4 no irq after 1", irq_n, 1'b1);
    cyc(0, 0, 0, 0, 0, "R6 ce low");
    check("R6 ce low hold", irq_n, 1'b1);
    cyc(1, 0, 0, 0, 0, "R4 second strobe");
    check("R4 irq after 256-L", irq_n, 1'b0);
    // R2: new reload value does not disturb running count
    cyc(0, 1, 0, 0, 8'hF0, "R2 reload while running");
    run_ce(2, "R8 further wraps");
    check("R8 stays low", irq_n, 1'b0);
    // R9: ack with ce high does not step; R7 restore bit 0 disables
    cyc(1, 0, 0, 1, 8'hFF, "R7 ack");
    check("R7 ack clears", irq_n, 1'b1);
    run_ce(400, "R7 disabled after ack keep=0");
    check("R7 enable dropped", irq_n, 1'b1);

    // R3: control write clears, reload FF, cycle mode with keep=1
    cyc(0, 1, 0, 0, 8'hFF, "R2 reload FF");
    cyc(0, 0, 1, 0, 8'h07, "R3 ctrl keep");
    cyc(1, 0, 0, 0, 0, "R4 L=FF each strobe");
    check("R4 wrap every strobe", irq_n, 1'b0);
    cyc(0, 0, 1, 0, 8'h07, "R3 ctrl clears pending");
    check("R3 ctrl clears", irq_n, 1'b1);
    cyc(1, 0, 0, 0, 0, "R4 wrap again");
    cyc(0, 0, 0, 1, 8'h00, "R7 ack keep=1");
    check("R7 ack clears keep", irq_n, 1'b1);
    cyc(1, 0, 0, 0, 0, "R7 still enabled");
    check("R7 restored enable counts", irq_n, 1'b0);

    // R5: scanline mode, L=FF, gaps 114,114,113
    cyc(0, 0, 1, 0, 8'h03, "R5 ctrl scanline");
    run_ce(113, "R5 before first step");
    check("R5 no step at 113", irq_n, 1'b1);
    cyc(1, 0, 0, 0, 0, "R5 step at 114");
    check("R5 step at 114", irq_n, 1'b0);
    cyc(0, 0, 0, 1, 0, "R5 ack");
    run_ce(113, "R5 second gap");
    check("R5 no step at 113 second", irq_n, 1'b1);
    cyc(1, 0, 0, 0, 0, "R5 second step");
    check("R5 second gap 114", irq_n, 1'b0);
    cyc(0, 0, 0, 1, 0, "R5 ack2");
    run_ce(112, "R5 third gap");
    check("R5 no step at 112", irq_n, 1'b1);
    cyc(1, 0, 0, 0, 0, "R5 third step");
    check("R5 third gap 113", irq_n, 1'b0);

    // R9: ctrl write with ce high: load, no step
    cyc(0, 1, 0, 0, 8'hFF, "R2 reload");
    cyc(1, 0, 1, 0, 8'h06, "R9 ctrl with ce");
    check("R9 no step on write", irq_n, 1'b1);

    // constrained random against the model
    for (int i = 0; i < 20000; i++) begin
      bit c, rl, ct, ak;
      logic [7:0] d;
      int unsigned r;
      r  = $urandom;
      c  = (r[1:0] != 2'b00);
      rl = (r[7:2] == 6'd0);
      ct = (r[13:8] == 6'd1);
      ak = (r[19:14] == 6'd2);
      d  = $urandom;
      if (rl && d[7]) d[6:4] = 3'b111;
      if (ct && r[21:20] != 2'b00) d[1] = 1'b1;
      cyc(c, rl, ct, ak, d, "R8 random vs model");
    end
    finish_run();
  end
endmodule